// File: doc/BRIEF.md
# Transmit Channel Source Selector with IQ Correction

This block is the datapath of one transmit channel. Four copies of it sit side by side, one for each channel of a four-channel converter interface. On every cycle it may accept a 32-bit upstream word that carries two signed 16-bit samples: the in-phase (I) sample in bits [15:0] and the quadrature (Q) sample in bits [31:16]. A control register chooses which word moves on. The choices are the upstream word itself, a tone made inside the block from a phase accumulator and a quarter-wave sine table, a fixed programmable 32-bit pattern, or all zeros.

The chosen word then goes through an IQ imbalance correction stage. The stage scales I, and it rebuilds Q from a weighted sum of Q and I. The weights are signed Q2.14 coefficients. When correction is turned off, the word passes through unchanged and takes the same number of cycles. A simple write-only register port sets the source, the pattern, the tone step and the three coefficients. Each sample carries with it the configuration that was in force on the edge at which it was accepted, so a register write never splits a sample already in the pipeline.

Top module: `tx_chan_srcsel`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0. The configuration resets to: source passthrough, correction off, pattern 0, tone increment 0, phase 0, c_ii = c_qq = 16384 and c_qi = 0.
- R2: A word accepted with in_valid high on rising edge A appears on out_data, with out_valid high, just after rising edge A+2 (three register stages). out_valid is in_valid delayed by that amount.
- R3: While out_valid is low, out_data is 0.
- R4: Select code 2'b10 passes the upstream in_data word.
- R5: Select code 2'b01 sends the 32-bit pattern register.
- R6: Select code 2'b00 sends a tone. A 32-bit phase accumulator starts at 0. It adds the increment register on every edge where in_valid is high and holds on every other edge. The sample uses the phase value before that edge's addition. With k = phase[31:26] and S(n) = round(32767*sin((2n+1)*pi/64)), the I lane is S(k) and the Q lane is S((k+16) mod 64). The tone is built from a 16-entry quarter-wave table.
- R7: Select code 2'b11 sends 0.
- R8: With control bit 2 set, the outputs are I' = sat((I*c_ii)>>>14) and Q' = sat((Q*c_qq + I*c_qi)>>>14). The shift is arithmetic (floor), and sat clips to the range -32768..32767.
- R9: With control bit 2 clear, the selected word reaches the output unchanged, whatever the coefficient values, with the R2 latency.
- R10: A sample uses the configuration held in the registers on the edge at which it is accepted. A register write on that same edge applies only to samples accepted later.
- R11: Register map for a write with wr_en high:
  - address 0: control, with [1:0] the select code and [2] the correction enable.
  - address 1: pattern.
  - address 2: tone increment.
  - addresses 3, 4 and 5: c_ii, c_qq and c_qi, taken from wr_data[15:0].
  - addresses 6 and 7: ignored, with no change to any configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream word is present this cycle |
| in_data | input | 32 | Upstream word, Q in [31:16], I in [15:0] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 32 | Output word, Q in [31:16], I in [15:0] |

## Verification
The bound assertions assume that in_valid and in_data are driven to known values at every clock edge after reset. Their checks reach three edges back only after three edges have passed since reset, and they read the select and enable values that the register port has set. The stimulus changes inputs and issues writes only on falling edges. It holds in_valid low through reset. It ends every scenario with idle cycles so that no word is left in flight when the next reset comes. The tone is compared with a tolerance of one code per lane, because the bench computes the sine itself.

// File: rtl/tx_chan_pkg.sv
`timescale 1ns/1ps
package tx_chan_pkg;

    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int FRAC_W   = 14;
    localparam int PHASE_W  = 32;
    localparam int ADDR_W   = 3;
    localparam int WORD_W   = 2 * SAMPLE_W;
    localparam int LUT_AW   = 4;
    localparam int TONE_AW  = LUT_AW + 2;

    typedef enum logic [1:0] {
        SRC_TONE    = 2'b00,
        SRC_PATTERN = 2'b01,
        SRC_PASS    = 2'b10,
        SRC_ZERO    = 2'b11
    } src_sel_e;

    typedef struct packed {
        src_sel_e                   sel;
        logic                       corr_en;
        logic [WORD_W-1:0]          pattern;
        logic [PHASE_W-1:0]         incr;
        logic signed [COEF_W-1:0]   c_ii;
        logic signed [COEF_W-1:0]   c_qq;
        logic signed [COEF_W-1:0]   c_qi;
    } chan_cfg_t;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_PAT   = 3'd1;
    localparam logic [ADDR_W-1:0] REG_INCR  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_C_II  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_C_QQ  = 3'd4;
    localparam logic [ADDR_W-1:0] REG_C_QI  = 3'd5;

    localparam logic signed [COEF_W-1:0] COEF_ONE = 16'sd16384;

    // Magnitude of sin((2i+1)*pi/64) scaled to full 16-bit signed range.
    function automatic logic [SAMPLE_W-1:0] quarter_mag(input logic [LUT_AW-1:0] i);
        unique case (i)
            4'd0:  return 16'd1608;
            4'd1:  return 16'd4808;
            4'd2:  return 16'd7962;
            4'd3:  return 16'd11039;
            4'd4:  return 16'd14010;
            4'd5:  return 16'd16846;
            4'd6:  return 16'd19519;
            4'd7:  return 16'd22005;
            4'd8:  return 16'd24279;
            4'd9:  return 16'd26319;
            4'd10: return 16'd28105;
            4'd11: return 16'd29621;
            4'd12: return 16'd30852;
            4'd13: return 16'd31785;
            4'd14: return 16'd32412;
            default: return 16'd32728;
        endcase
    endfunction

endpackage

// File: rtl/tx_chan_regs.sv
`timescale 1ns/1ps
module tx_chan_regs
    import tx_chan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output chan_cfg_t           cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.sel     <= SRC_PASS;
            cfg.corr_en <= 1'b0;
            cfg.pattern <= '0;
            cfg.incr    <= '0;
            cfg.c_ii    <= COEF_ONE;
            cfg.c_qq    <= COEF_ONE;
            cfg.c_qi    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_CTRL: begin
                    cfg.sel     <= src_sel_e'(wr_data[1:0]);
                    cfg.corr_en <= wr_data[2];
                end
                REG_PAT:  cfg.pattern <= wr_data;
                REG_INCR: cfg.incr    <= wr_data[PHASE_W-1:0];
                REG_C_II: cfg.c_ii    <= wr_data[COEF_W-1:0];
                REG_C_QQ: cfg.c_qq    <= wr_data[COEF_W-1:0];
                REG_C_QI: cfg.c_qi    <= wr_data[COEF_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tx_tone_gen.sv
`timescale 1ns/1ps
module tx_tone_gen
    import tx_chan_pkg::*;
#(
    parameter int PH_W = PHASE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic [PH_W-1:0]     incr,
    output logic [PH_W-1:0]     phase,
    output logic [WORD_W-1:0]   tone
);

    localparam int QUAD_OFS = 1 << LUT_AW;

    logic [TONE_AW-1:0] idx_i;
    logic [TONE_AW-1:0] idx_q;

    function automatic logic [SAMPLE_W-1:0] wave(input logic [TONE_AW-1:0] k);
        logic [LUT_AW-1:0]   pos;
        logic [SAMPLE_W-1:0] mag;
        pos = k[TONE_AW-2] ? ~k[LUT_AW-1:0] : k[LUT_AW-1:0];
        mag = quarter_mag(pos);
        return k[TONE_AW-1] ? (~mag + 1'b1) : mag;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (advance) begin
            phase <= phase + incr;
        end
    end

    always_comb begin
        idx_i = phase[PH_W-1 -: TONE_AW];
        idx_q = idx_i + TONE_AW'(QUAD_OFS);
        tone  = {wave(idx_q), wave(idx_i)};
    end

endmodule

// File: rtl/tx_iq_corr.sv
`timescale 1ns/1ps
module tx_iq_corr
    import tx_chan_pkg::*;
#(
    parameter int S_W = SAMPLE_W,
    parameter int C_W = COEF_W,
    parameter int F_W = FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2*S_W-1:0]    in_word,
    input  logic                corr_en,
    input  logic signed [C_W-1:0] c_ii,
    input  logic signed [C_W-1:0] c_qq,
    input  logic signed [C_W-1:0] c_qi,
    output logic                out_valid,
    output logic [2*S_W-1:0]    out_word
);

    localparam int PW = S_W + C_W;
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] SAT_HI = SW'((64'sd1 <<< (S_W - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] SAT_LO = -SAT_HI - SW'(1);

    logic signed [S_W-1:0] smp_i;
    logic signed [S_W-1:0] smp_q;

    logic                  a_valid;
    logic                  a_en;
    logic [2*S_W-1:0]      a_word;
    logic signed [PW-1:0]  p_ii;
    logic signed [PW-1:0]  p_qq;
    logic signed [PW-1:0]  p_qi;

    logic signed [SW-1:0]  sum_i;
    logic signed [SW-1:0]  sum_q;
    logic [2*S_W-1:0]      result;

    function automatic logic [S_W-1:0] clip(input logic signed [SW-1:0] v);
        if (v > SAT_HI)      return SAT_HI[S_W-1:0];
        else if (v < SAT_LO) return SAT_LO[S_W-1:0];
        else                 return v[S_W-1:0];
    endfunction

    assign smp_i = in_word[S_W-1:0];
    assign smp_q = in_word[2*S_W-1:S_W];

    // Stage A: multipliers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_en    <= 1'b0;
            a_word  <= '0;
            p_ii    <= '0;
            p_qq    <= '0;
            p_qi    <= '0;
        end else begin
            a_valid <= in_valid;
            a_en    <= corr_en;
            a_word  <= in_word;
            p_ii    <= PW'(smp_i) * PW'(c_ii);
            p_qq    <= PW'(smp_q) * PW'(c_qq);
            p_qi    <= PW'(smp_i) * PW'(c_qi);
        end
    end

    // Stage B: sum, scale, clip, bypass select
    always_comb begin
        sum_i  = SW'(p_ii) >>> F_W;
        sum_q  = (SW'(p_qq) + SW'(p_qi)) >>> F_W;
        result = a_en ? {clip(sum_q), clip(sum_i)} : a_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= a_valid;
            out_word  <= a_valid ? result : '0;
        end
    end

endmodule

// File: rtl/tx_chan_srcsel.sv
`timescale 1ns/1ps
module tx_chan_srcsel
    import tx_chan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data
);

    chan_cfg_t              cfg;
    logic [PHASE_W-1:0]     tone_phase;
    logic [WORD_W-1:0]      tone_word;
    logic [WORD_W-1:0]      pick;

    // Stage 1 registers: selected word plus configuration snapshot
    logic                   s1_valid;
    logic [WORD_W-1:0]      s1_word;
    logic                   s1_en;
    logic signed [COEF_W-1:0] s1_c_ii;
    logic signed [COEF_W-1:0] s1_c_qq;
    logic signed [COEF_W-1:0] s1_c_qi;

    tx_chan_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    tx_tone_gen #(.PH_W(PHASE_W)) u_tone (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .incr    (cfg.incr),
        .phase   (tone_phase),
        .tone    (tone_word)
    );

    always_comb begin
        unique case (cfg.sel)
            SRC_TONE:    pick = tone_word;
            SRC_PATTERN: pick = cfg.pattern;
            SRC_PASS:    pick = in_data;
            SRC_ZERO:    pick = '0;
            default:     pick = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_word  <= '0;
            s1_en    <= 1'b0;
            s1_c_ii  <= COEF_ONE;
            s1_c_qq  <= COEF_ONE;
            s1_c_qi  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_word  <= pick;
            s1_en    <= cfg.corr_en;
            s1_c_ii  <= cfg.c_ii;
            s1_c_qq  <= cfg.c_qq;
            s1_c_qi  <= cfg.c_qi;
        end
    end

    tx_iq_corr #(
        .S_W (SAMPLE_W),
        .C_W (COEF_W),
        .F_W (FRAC_W)
    ) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_valid),
        .in_word   (s1_word),
        .corr_en   (s1_en),
        .c_ii      (s1_c_ii),
        .c_qq      (s1_c_qq),
        .c_qi      (s1_c_qi),
        .out_valid (out_valid),
        .out_word  (out_data)
    );

endmodule

// File: rtl/tx_chan_srcsel_chk.sv
`timescale 1ns/1ps
module tx_chan_srcsel_chk (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        out_valid,
    input  logic [31:0] out_data,
    input  logic [1:0]  cur_sel,
    input  logic        cur_en,
    input  logic [31:0] phase
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));                 // R2

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == 32'd0));                                         // R3

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid && cur_sel == 2'b10 && !cur_en, 3))
        |-> (out_data == $past(in_data, 3)));                                        // R9

    AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid && cur_sel == 2'b11, 3))
        |-> (out_data == 32'd0));                                                    // R7

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase));                                               // R6

endmodule

bind tx_chan_srcsel tx_chan_srcsel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .cur_sel   (cfg.sel),
    .cur_en    (cfg.corr_en),
    .phase     (tone_phase)
);

// File: tb/tx_chan_srcsel_tb.sv
`timescale 1ns/1ps
module tx_chan_srcsel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";

    // Bench model of configuration, taken from the requirements
    int          m_sel;
    bit          m_en;
    logic [31:0] m_pat, m_inc, m_phase;
    longint      m_c1, m_c2, m_c3;
    logic        ev [3];
    logic [31:0] ed [3];
    bit          et [3];

    always #2.5 clk = ~clk;

    tx_chan_srcsel u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [15:0] sine_s(int n);
        real x;
        int  r;
        x = $sin((2.0 * n + 1.0) * 3.14159265358979 / 64.0) * 32767.0;
        if (x >= 0.0) r = $rtoi(x + 0.5);
        else          r = -$rtoi(-x + 0.5);
        return 16'(r);
    endfunction

    function automatic logic [15:0] clip(longint v);
        if (v > 32767)  return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return 16'(v);
    endfunction

    function automatic logic [31:0] model_word(logic [31:0] d);
        logic [31:0] w;
        longint      vi, vq;
        int          k;
        k = int'(m_phase[31:26]);
        case (m_sel)
            0:       w = {sine_s((k + 16) % 64), sine_s(k)};
            1:       w = m_pat;
            2:       w = d;
            default: w = 32'd0;
        endcase
        if (m_en) begin
            vi = longint'($signed(w[15:0]));
            vq = longint'($signed(w[31:16]));
            w  = {clip((vq * m_c2 + vi * m_c3) >>> 14), clip((vi * m_c1) >>> 14)};
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 2; m_en = 0; m_pat = 0; m_inc = 0; m_phase = 0;
            m_c1 = 16384; m_c2 = 16384; m_c3 = 0;
            for (int i = 0; i < 3; i++) begin ev[i] = 0; ed[i] = 0; et[i] = 0; end
        end else begin
            ev[2] = ev[1]; ed[2] = ed[1]; et[2] = et[1];
            ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
            ev[0] = in_valid;
            ed[0] = in_valid ? model_word(in_data) : 32'd0;
            et[0] = in_valid && m_sel == 0 && !m_en;
            if (in_valid) m_phase = m_phase + m_inc;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_sel = int'(wr_data[1:0]); m_en = wr_data[2]; end
                    3'd1: m_pat = wr_data;
                    3'd2: m_inc = wr_data;
                    3'd3: m_c1 = longint'($signed(wr_data[15:0]));
                    3'd4: m_c2 = longint'($signed(wr_data[15:0]));
                    3'd5: m_c3 = longint'($signed(wr_data[15:0]));
                    default: ;
                endcase
            end
        end
    end

    function automatic bit near(logic [31:0] a, logic [31:0] b);
        int di, dq;
        di = int'($signed(a[15:0])) - int'($signed(b[15:0]));
        dq = int'($signed(a[31:16])) - int'($signed(b[31:16]));
        return (di >= -1 && di <= 1 && dq >= -1 && dq <= 1);
    endfunction

    // Output monitor, sampled on falling edges
    always @(negedge clk) begin
        if (chk_on) begin
            n_chk++;
            if (out_valid !== ev[2]) begin
                n_fail++;
                $display("FAIL R2 (%s): out_valid=%0b expected %0b", cur_req, out_valid, ev[2]);
            end else if (!ev[2] && out_data !== 32'd0) begin
                n_fail++;
                $display("FAIL R3: out_data=%h expected 00000000", out_data);
            end else if (ev[2] && !(et[2] ? near(out_data, ed[2]) : out_data === ed[2])) begin
                n_fail++;
                $display("FAIL %s: out_data=%h expected %h", cur_req, out_data, ed[2]);
            end
        end
    end

    task automatic cyc(input logic v, input logic [31:0] d,
                       input logic w = 1'b0, input logic [2:0] a = 3'd0,
                       input logic [31:0] wd = 32'd0);
        in_valid = v; in_data = d; wr_en = w; wr_addr = a; wr_data = wd;
        @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] wd);
        cyc(1'b0, 32'd0, 1'b1, a, wd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        chk_on = 0; rst_n = 0;
        in_valid = 0; wr_en = 0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 32'd0) begin
            n_fail++;
            $display("FAIL R1: out_valid=%0b out_data=%h expected 0 and 00000000", out_valid, out_data);
        end
        rst_n = 1;
        chk_on = 1;
    endtask

    task automatic t_reset_defaults();
        do_reset();
        cur_req = "R1";
        cyc(1'b1, 32'h8001_7FFF);
        cyc(1'b1, 32'h1234_ABCD);
        idle(4);
    endtask

    task automatic t_passthrough();
        do_reset();
        cur_req = "R4";
        for (int i = 0; i < 12; i++)
            cyc((i % 4) != 3, 32'h0101_0101 * (i + 1) ^ 32'hA5A5_0F0F);
        idle(4);
    endtask

    task automatic t_pattern();
        do_reset();
        cur_req = "R5";
        wreg(3'd1, 32'hDEAD_BEEF);
        wreg(3'd0, 32'd1);
        for (int i = 0; i < 6; i++) cyc(i != 2, 32'h1111_1111 * i);
        idle(4);
    endtask

    task automatic t_tone();
        do_reset();
        cur_req = "R6";
        wreg(3'd2, 32'h0500_0000);
        wreg(3'd0, 32'd0);
        for (int i = 0; i < 70; i++) cyc((i % 3) != 0, 32'hFFFF_FFFF);
        wreg(3'd2, 32'hF7C0_0000);
        for (int i = 0; i < 30; i++) cyc(1'b1, 32'd0);
        idle(4);
    endtask

    task automatic t_zero();
        do_reset();
        cur_req = "R7";
        wreg(3'd0, 32'd3);
        for (int i = 0; i < 5; i++) cyc(1'b1, 32'h7FFF_7FFF);
        wreg(3'd0, 32'd7);
        for (int i = 0; i < 5; i++) cyc(1'b1, 32'h8000_1234);
        idle(4);
    endtask

    task automatic t_correction();
        do_reset();
        cur_req = "R8";
        wreg(3'd3, 32'd12000);
        wreg(3'd4, 32'h0000_DCD8);
        wreg(3'd5, 32'd5000);
        wreg(3'd0, 32'd6);
        cyc(1'b1, 32'h1000_2000);
        cyc(1'b1, 32'hF000_E123);
        cyc(1'b1, 32'h0001_FFFF);
        cyc(1'b1, 32'h7654_89AB);
        idle(3);
        wreg(3'd3, 32'd32767);
        wreg(3'd4, 32'd32767);
        wreg(3'd5, 32'd32767);
        cyc(1'b1, 32'h7FFF_7FFF);
        cyc(1'b1, 32'h8000_8000);
        cyc(1'b1, 32'h8000_7FFF);
        cyc(1'b1, 32'h0001_FFFF);
        idle(4);
    endtask

    task automatic t_bypass();
        do_reset();
        cur_req = "R9";
        wreg(3'd3, 32'h0000_9000);
        wreg(3'd5, 32'd7000);
        wreg(3'd0, 32'd2);
        for (int i = 0; i < 6; i++) cyc(1'b1, 32'h7FFF_8000 + 32'h0F0F_1111 * i);
        idle(4);
    endtask

    task automatic t_snapshot();
        do_reset();
        cur_req = "R10";
        wreg(3'd1, 32'h0BAD_F00D);
        cyc(1'b1, 32'h4000_4000, 1'b1, 3'd0, 32'd6);
        cyc(1'b1, 32'h4000_4000, 1'b1, 3'd3, 32'd8192);
        cyc(1'b1, 32'h4000_C000, 1'b1, 3'd5, 32'h0000_E000);
        cyc(1'b1, 32'h2000_1000, 1'b1, 3'd0, 32'd5);
        cyc(1'b1, 32'h2000_1000, 1'b1, 3'd0, 32'd2);
        cyc(1'b1, 32'h3333_4444, 1'b1, 3'd0, 32'd3);
        cyc(1'b1, 32'h5555_6666);
        idle(4);
    endtask

    task automatic t_bad_addr();
        do_reset();
        cur_req = "R11";
        wreg(3'd6, 32'h0000_0005);
        wreg(3'd7, 32'h0000_0001);
        for (int i = 0; i < 4; i++) cyc(1'b1, 32'hC0DE_0000 + i);
        wreg(3'd0, 32'd1);
        wreg(3'd6, 32'hFFFF_FFFF);
        wreg(3'd7, 32'h0000_0000);
        for (int i = 0; i < 4; i++) cyc(1'b1, 32'h0000_1111 * i);
        idle(4);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset_defaults();
        t_passthrough();
        t_pattern();
        t_tone();
        t_zero();
        t_correction();
        t_bypass();
        t_snapshot();
        t_bad_addr();
        chk_on = 0;
        summary();
        $finish;
    end

endmodule